// File: doc/BRIEF.md
# Four-Channel Fly-By Block DMA Controller

This block moves whole blocks of words between a peripheral port and system memory on behalf of a CPU, without the data ever passing through it. Each of the four channels is loaded by the CPU with a start address, a word count and a direction. Writing a channel arms it when the count is nonzero. A peripheral asks for service by raising its request line. The controller then asks the CPU for the buses, waits for the grant, acknowledges the peripheral, and holds the buses until every word of the block has moved.

For each word the controller drives the memory address and issues two strobe phases. In the first phase only the source strobe is active. In the second phase the destination strobe is added while the source strobe is held. The memory and the peripheral exchange the word directly on the shared data bus during that second phase. After the last word, the channel's terminal-count flag is set, the interrupt output rises and the buses are released. Only one channel is active at a time. Channel 0 wins when several requests arrive together, and a running block is never pre-empted.

Top module: `dma_flyby_top`

## Requirements
- R1: While reset is applied, and in the cycle after it, bus_req, periph_ack, all four strobes, addr_out, tc_flags and irq are zero. Reset also disarms every channel.
- R2: An armed channel's request raises bus_req. bus_req stays high until the block's final word, and it is low in the cycle after the terminal-count flag sets.
- R3: No acknowledge or strobe is issued before bus_grant is seen high. periph_ack is one-hot to the channel being served, or zero.
- R4: With cfg_dir=0 (memory to peripheral), each word is one cycle of mem_rd alone, then one cycle of mem_rd with io_wr. The peripheral receives the memory word at addr_out.
- R5: With cfg_dir=1 (peripheral to memory), each word is one cycle of io_rd alone, then one cycle of io_rd with mem_wr. Memory at addr_out receives the peripheral word.
- R6: A block moves exactly the programmed number of words, at addresses start, start+1, and so on upward.
- R7: After the last word, the channel's tc_flags bit sets and the channel disarms. irq is the OR of tc_flags. Reprogramming a channel clears its tc_flags bit.
- R8: When several armed channels request at once, the lowest-numbered channel is served first.
- R9: A request that arrives during a block waits until that block ends. The acknowledged channel does not change within a block.
- R10: A request on a channel that is unarmed (never loaded, loaded with count 0, or already finished) leaves bus_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the channel selected by cfg_ch |
| cfg_ch | input | 2 | Channel to load |
| cfg_addr | input | ADDR_W | Start memory address |
| cfg_count | input | CNT_W | Number of words; 0 leaves the channel unarmed |
| cfg_dir | input | 1 | 0 = memory to peripheral, 1 = peripheral to memory |
| periph_req | input | 4 | Per-channel service request from the peripherals |
| periph_ack | output | 4 | Per-channel acknowledge, held for the whole block |
| bus_req | output | 1 | Bus request to the CPU |
| bus_grant | input | 1 | Bus grant from the CPU |
| addr_out | output | ADDR_W | Memory address during the strobe phases, else zero |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| tc_flags | output | 4 | Per-channel terminal-count flags |
| irq | output | 1 | Interrupt to the CPU, the OR of tc_flags |

## Verification
The embedded properties watch the handshake and strobe ordering on every cycle. They check that the acknowledge is one-hot and only rises after a grant, and that every destination strobe is preceded and accompanied by its source strobe. They also check that the served channel never changes mid-block and that the bus request drops only when a terminal-count flag has just set. Data integrity through the shared bus, the exact word count and address run, fixed-priority ordering, non-pre-emption, flag clearing and the handling of unarmed requests can only be shown by the bench's scenarios. For these, a memory and a peripheral model log every word.

// File: rtl/dma_pkg.sv
// Shared types for the fly-by DMA controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package dma_pkg;

    // Sequencer states: idle, waiting for grant, acknowledge, source phase, destination phase.
    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_GRANT = 3'd1,
        SEQ_ACK   = 3'd2,
        SEQ_SRC   = 3'd3,
        SEQ_DST   = 3'd4
    } seq_state_t;

    // Transfer direction as programmed by the CPU.
    typedef enum logic {
        DIR_MEM2IO = 1'b0,
        DIR_IO2MEM = 1'b1
    } xfer_dir_t;

endpackage

// File: rtl/dma_chan_regs.sv
// Per-channel programming state: address, remaining count, direction,
// armed bit and terminal-count flag. A CPU load takes priority over a word
// step. Assumes the CPU does not reload the channel being served.
module dma_chan_regs
    import dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_dir,
    input  logic              step,
    input  logic [CH_W-1:0]   sel_ch,
    output logic [ADDR_W-1:0] sel_addr,
    output logic [CNT_W-1:0]  sel_count,
    output xfer_dir_t         sel_dir,
    output logic [NUM_CH-1:0] armed,
    output logic [NUM_CH-1:0] tc
);

    logic [ADDR_W-1:0] addr_q [NUM_CH];
    logic [CNT_W-1:0]  cnt_q  [NUM_CH];
    xfer_dir_t         dir_q  [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit_cfg;
        logic hit_step;
        assign hit_cfg  = cfg_we && (cfg_ch == CH_W'(g));
        assign hit_step = step && (sel_ch == CH_W'(g));

        // Load from the CPU, or advance one word while this channel is served.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
                cnt_q[g]  <= '0;
                dir_q[g]  <= DIR_MEM2IO;
                armed[g]  <= 1'b0;
                tc[g]     <= 1'b0;
            end else if (hit_cfg) begin
                addr_q[g] <= cfg_addr;
                cnt_q[g]  <= cfg_count;
                dir_q[g]  <= xfer_dir_t'(cfg_dir);
                armed[g]  <= (cfg_count != '0);
                tc[g]     <= 1'b0;
            end else if (hit_step) begin
                addr_q[g] <= addr_q[g] + 1'b1;
                cnt_q[g]  <= cnt_q[g] - 1'b1;
                if (cnt_q[g] == CNT_W'(1)) begin
                    armed[g] <= 1'b0;
                    tc[g]    <= 1'b1;
                end
            end
        end

        // R7
        tc_means_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tc[g]) |-> !armed[g] && $past(armed[g]));
    end

    // Present the state of the channel under service to the sequencer.
    always_comb begin
        sel_addr  = addr_q[sel_ch];
        sel_count = cnt_q[sel_ch];
        sel_dir   = dir_q[sel_ch];
    end

endmodule

// File: rtl/dma_prio_arb.sv
// Fixed-priority pick among armed requesting channels; the lowest index wins.
// Purely combinational; the sequencer samples it only while idle.
module dma_prio_arb #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic [NUM_CH-1:0] req,
    output logic              valid,
    output logic [CH_W-1:0]   idx
);

    // Scan from the top so the lowest-numbered requester is the last to write.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_xfer_seq.sv
// Block sequencer: requests the buses, waits for the grant, acknowledges the
// peripheral, then runs a source phase and a destination phase per word until
// the count of the latched channel is spent. Assumes the grant stays high
// for as long as the request does.
module dma_xfer_seq
    import dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pick_valid,
    input  logic [CH_W-1:0]   pick_ch,
    input  logic              bus_grant,
    input  logic [CNT_W-1:0]  cur_count,
    input  xfer_dir_t         cur_dir,
    output logic [CH_W-1:0]   cur_ch,
    output logic              bus_req,
    output logic [NUM_CH-1:0] ack_vec,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              addr_en,
    output logic              step
);

    seq_state_t state;
    logic       active;
    logic       is_src;
    logic       is_dst;
    logic       m2io;

    // State register and channel latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            cur_ch <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: if (pick_valid) begin
                    cur_ch <= pick_ch;
                    state  <= SEQ_GRANT;
                end
                SEQ_GRANT: if (bus_grant) state <= SEQ_ACK;
                SEQ_ACK:   state <= SEQ_SRC;
                SEQ_SRC:   state <= SEQ_DST;
                SEQ_DST:   state <= (cur_count == CNT_W'(1)) ? SEQ_IDLE : SEQ_SRC;
                default:   state <= SEQ_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state and the programmed direction.
    always_comb begin
        active  = (state == SEQ_ACK) || (state == SEQ_SRC) || (state == SEQ_DST);
        is_src  = (state == SEQ_SRC);
        is_dst  = (state == SEQ_DST);
        m2io    = (cur_dir == DIR_MEM2IO);
        bus_req = (state != SEQ_IDLE);
        addr_en = is_src || is_dst;
        step    = is_dst;
        mem_rd  = m2io && (is_src || is_dst);
        io_wr   = m2io && is_dst;
        io_rd   = !m2io && (is_src || is_dst);
        mem_wr  = !m2io && is_dst;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ack
        assign ack_vec[g] = active && (cur_ch == CH_W'(g));
    end

    // R3
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_vec));

    // R3
    ack_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ack_vec) |-> $past(bus_grant));

    // R9
    served_ch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(cur_ch));

endmodule

// File: rtl/dma_flyby_top.sv
// Four-channel fly-by block DMA controller top level. Joins the channel
// register file, the fixed-priority arbiter and the block sequencer. Data
// never enters this block: memory and peripheral meet on the system data bus
// during the destination phase. Assumes the CPU does not reprogram a channel
// while it is being served and keeps the grant high while the request is high.
module dma_flyby_top
    import dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_dir,
    input  logic [NUM_CH-1:0] periph_req,
    output logic [NUM_CH-1:0] periph_ack,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic [ADDR_W-1:0] addr_out,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [NUM_CH-1:0] tc_flags,
    output logic              irq
);

    logic [CH_W-1:0]   cur_ch;
    logic [ADDR_W-1:0] sel_addr;
    logic [CNT_W-1:0]  sel_count;
    xfer_dir_t         sel_dir;
    logic [NUM_CH-1:0] armed;
    logic              pick_valid;
    logic [CH_W-1:0]   pick_ch;
    logic              addr_en;
    logic              step;

    dma_chan_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .CH_W   (CH_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_addr  (cfg_addr),
        .cfg_count (cfg_count),
        .cfg_dir   (cfg_dir),
        .step      (step),
        .sel_ch    (cur_ch),
        .sel_addr  (sel_addr),
        .sel_count (sel_count),
        .sel_dir   (sel_dir),
        .armed     (armed),
        .tc        (tc_flags)
    );

    dma_prio_arb #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) arb_i (
        .req   (periph_req & armed),
        .valid (pick_valid),
        .idx   (pick_ch)
    );

    dma_xfer_seq #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .CH_W   (CH_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick_valid (pick_valid),
        .pick_ch    (pick_ch),
        .bus_grant  (bus_grant),
        .cur_count  (sel_count),
        .cur_dir    (sel_dir),
        .cur_ch     (cur_ch),
        .bus_req    (bus_req),
        .ack_vec    (periph_ack),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .addr_en    (addr_en),
        .step       (step)
    );

    // Drive the address only during strobe phases; raise the interrupt on any flag.
    always_comb begin
        addr_out = addr_en ? sel_addr : '0;
        irq      = |tc_flags;
    end

    // R4
    m2io_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |-> mem_rd && $past(mem_rd) && !$past(io_wr));

    // R5
    io2m_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> io_rd && $past(io_rd) && !$past(mem_wr));

    // R2
    release_on_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> |(tc_flags & ~$past(tc_flags)));

    // R3
    no_mixed_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((mem_rd || io_wr) && (io_rd || mem_wr)));

endmodule

// File: tb/dma_flyby_top_tb_top.sv
`timescale 1ns/1ps
module dma_flyby_top_tb_top;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_ch = '0;
    logic [AW-1:0]  cfg_addr = '0;
    logic [CW-1:0]  cfg_count = '0;
    logic           cfg_dir = 1'b0;
    logic [NCH-1:0] periph_req = '0;
    logic [NCH-1:0] periph_ack;
    logic           bus_req;
    logic           bus_grant = 1'b0;
    logic [AW-1:0]  addr_out;
    logic           mem_rd, mem_wr, io_rd, io_wr;
    logic [NCH-1:0] tc_flags;
    logic           irq;

    int checks = 0;
    int fails  = 0;
    int grant_delay = 2;
    int gcnt = 0;
    int viol = 0;
    int cyc = 0;

    logic [7:0] mem [256];
    logic [7:0] bus_data;
    int         log_n = 0;
    int         log_addr [256];
    int         log_ch   [256];
    int         log_dir  [256];
    int         log_data [256];

    always #2.5 clk = ~clk;

    dma_flyby_top #(.NUM_CH(NCH), .ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_addr(cfg_addr), .cfg_count(cfg_count), .cfg_dir(cfg_dir),
        .periph_req(periph_req), .periph_ack(periph_ack), .bus_req(bus_req),
        .bus_grant(bus_grant), .addr_out(addr_out), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .tc_flags(tc_flags),
        .irq(irq)
    );

    // CPU model: grants the buses grant_delay cycles after the request.
    always @(posedge clk) begin
        if (bus_req) begin
            if (gcnt >= grant_delay) bus_grant <= 1'b1;
            else gcnt <= gcnt + 1;
        end else begin
            bus_grant <= 1'b0;
            gcnt <= 0;
        end
    end

    // Shared data bus: the source of the current word drives it.
    always_comb begin
        if (mem_rd) bus_data = mem[addr_out[7:0]];
        else if (io_rd) bus_data = 8'hC0 ^ 8'(log_n);
        else bus_data = 8'h00;
    end

    // Memory and peripheral sinks plus the word log, sampled mid-cycle.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (((|periph_ack) || mem_rd || mem_wr || io_rd || io_wr) && !bus_grant)
            viol <= viol + 1;
        if ((io_wr && mem_rd) || (mem_wr && io_rd)) begin
            if (log_n < 256) begin
                log_addr[log_n] = int'(addr_out);
                log_dir[log_n]  = mem_wr ? 1 : 0;
                log_data[log_n] = int'(bus_data);
                log_ch[log_n]   = -1;
                for (int k = 0; k < NCH; k++) if (periph_ack[k]) log_ch[log_n] = k;
            end
            if (mem_wr) mem[addr_out[7:0]] = bus_data;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic program_ch(input int ch, input int addr, input int cnt, input int dir);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_addr = AW'(addr);
        cfg_count = CW'(cnt); cfg_dir = dir[0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_tc(input int ch);
        while (!tc_flags[ch]) @(negedge clk);
    endtask

    // Stimulus table: channel, direction, start address, word count.
    localparam int NV = 5;
    localparam int V_CH   [NV] = '{0, 1, 2, 3, 0};
    localparam int V_DIR  [NV] = '{0, 1, 0, 1, 0};
    localparam int V_ADDR [NV] = '{16, 64, 128, 160, 64};
    localparam int V_CNT  [NV] = '{4, 3, 1, 7, 3};

    initial begin
        int base;
        int exp_data [64];
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 3 + 1);
        repeat (3) @(negedge clk);
        // R1: outputs idle while reset is applied
        chk(bus_req == 0 && periph_ack == 0 && tc_flags == 0 && irq == 0, "R1 reset idle", int'(bus_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!(mem_rd || mem_wr || io_rd || io_wr) && addr_out == 0, "R1 strobes idle", int'(addr_out), 0);

        for (int v = 0; v < NV; v++) begin
            program_ch(V_CH[v], V_ADDR[v], V_CNT[v], V_DIR[v]);
            base = log_n;
            for (int i = 0; i < V_CNT[v]; i++) exp_data[i] = int'(mem[V_ADDR[v] + i]);
            periph_req[V_CH[v]] = 1'b1;
            @(negedge clk);
            // R2: armed request raises the bus request
            chk(bus_req == 1, "R2 bus_req raised", int'(bus_req), 1);
            wait_tc(V_CH[v]);
            // R2: bus released right after the flag sets
            chk(bus_req == 0, "R2 bus_req released", int'(bus_req), 0);
            // R7: flag and interrupt
            chk(irq == 1, "R7 irq on tc", int'(irq), 1);
            // R6: exact word count
            chk(log_n - base == V_CNT[v], "R6 word count", log_n - base, V_CNT[v]);
            for (int i = 0; i < V_CNT[v]; i++) begin
                chk(log_addr[base + i] == V_ADDR[v] + i, "R6 address run", log_addr[base + i], V_ADDR[v] + i);
                chk(log_ch[base + i] == V_CH[v], "R3 ack channel", log_ch[base + i], V_CH[v]);
                chk(log_dir[base + i] == V_DIR[v], "R4 R5 direction", log_dir[base + i], V_DIR[v]);
                if (V_DIR[v] == 0)
                    chk(log_data[base + i] == exp_data[i], "R4 peripheral data", log_data[base + i], exp_data[i]);
                else
                    chk(int'(mem[V_ADDR[v] + i]) == int'(8'hC0 ^ 8'(base + i)), "R5 memory data",
                        int'(mem[V_ADDR[v] + i]), int'(8'hC0 ^ 8'(base + i)));
            end
            periph_req = '0;
            @(negedge clk);
        end

        // R10: finished channels stay quiet when requested again
        periph_req = 4'hF;
        repeat (6) @(negedge clk);
        chk(bus_req == 0, "R10 done channels ignored", int'(bus_req), 0);
        periph_req = '0;

        // R7: reprogramming with count 0 clears flags and interrupt
        for (int c = 0; c < NCH; c++) program_ch(c, 0, 0, 0);
        chk(tc_flags == 0 && irq == 0, "R7 flags cleared", int'(tc_flags), 0);
        periph_req = 4'hF;
        repeat (6) @(negedge clk);
        chk(bus_req == 0, "R10 zero count ignored", int'(bus_req), 0);
        periph_req = '0;

        // R8: simultaneous requests, lowest channel first
        program_ch(3, 48, 3, 0);
        program_ch(1, 32, 2, 0);
        base = log_n;
        periph_req = 4'b1010;
        wait_tc(1);
        wait_tc(3);
        chk(log_ch[base] == 1 && log_ch[base + 1] == 1, "R8 channel 1 first", log_ch[base], 1);
        chk(log_ch[base + 2] == 3, "R8 channel 3 second", log_ch[base + 2], 3);
        periph_req = '0;

        // R9: higher priority request mid-block waits
        program_ch(2, 80, 5, 1);
        program_ch(0, 96, 2, 0);
        base = log_n;
        periph_req = 4'b0100;
        while (!periph_ack[2]) @(negedge clk);
        periph_req = 4'b0101;
        wait_tc(0);
        for (int i = 0; i < 5; i++)
            chk(log_ch[base + i] == 2, "R9 no pre-emption", log_ch[base + i], 2);
        chk(log_ch[base + 5] == 0, "R9 waiting channel served next", log_ch[base + 5], 0);
        periph_req = '0;

        // R3: long grant delay, acknowledge waits for it
        grant_delay = 7;
        program_ch(1, 200, 2, 0);
        periph_req = 4'b0010;
        while (!bus_req) @(negedge clk);
        begin
            int waited = 0;
            while (!periph_ack[1] && waited < 100) begin @(negedge clk); waited++; end
            chk(waited >= 7, "R3 ack waits for grant", waited, 7);
        end
        wait_tc(1);
        periph_req = '0;
        chk(viol == 0, "R3 no activity without grant", viol, 0);
        grant_delay = 2;

        // R1: reset in the middle of a block
        program_ch(3, 192, 10, 0);
        periph_req = 4'b1000;
        while (!periph_ack[3]) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(bus_req == 0 && periph_ack == 0 && !(mem_rd || io_wr) && tc_flags == 0,
            "R1 mid-block reset", int'(periph_ack), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(bus_req == 0, "R1 reset disarms", int'(bus_req), 0);
        periph_req = '0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        wait (cyc > 50000);
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

endmodule